// File: doc/BRIEF.md
# Lane-Serial Local Memory Access Engine

This block carries out one vector access to a local scratch memory on behalf of a group of lanes. The caller presents a per-lane byte base address, a lane enable mask, one or two immediate byte offsets and a mode, then pulses `start_i`. The engine visits the enabled lanes one after another against a single-port 32-bit scratch RAM that it contains. For each lane it moves data between that RAM and a slot file of 64-bit data slots.

In single mode a lane touches one element at base plus `off0_i`, and that element maps to slot *lane*. In dual mode a lane touches two elements, one at base plus `off0_i` and one at base plus `off1_i`, and these map to slots 2·lane and 2·lane+1. An element is either 32 or 64 bits wide. A 64-bit element is split into two RAM words: the low word is at the element address and the high word is at the address plus 4.

Reads fill the slot file, which stays visible on `slots_o`. Writes take their data from the `wdata_i` slot vector, which the caller holds stable while `busy_o` is high. A one-cycle `done_o` pulse closes each operation.

Top module: `lds_lane_walker`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and every slot on `slots_o` is zero.
- R2: A lane whose `mask_i` bit is clear makes no RAM access, and its slots keep their previous values.
- R3: In single mode (`dual_i`=0), an enabled lane accesses byte address base+`off0_i` using slot index *lane*. Byte address arithmetic wraps modulo the RAM size in bytes.
- R4: In a dual-mode read, an enabled lane loads slot 2·lane from base+`off0_i` and slot 2·lane+1 from base+`off1_i`.
- R5: In a dual-mode write, an enabled lane stores slot 2·lane of `wdata_i` at base+`off0_i` and slot 2·lane+1 at base+`off1_i`. A write never changes `slots_o`.
- R6: With `wide_i`=1 an element is 64 bits: bits 31:0 are at the element address and bits 63:32 at the element address+4. With `wide_i`=0 an element is 32 bits: a read sets the slot to the zero-extended word, and a write stores slot bits 31:0.
- R7: Accesses occur in ascending lane order. Within a lane the `off0_i` element comes before the `off1_i` element, and the low word comes before the high word. When two accesses write the same word, the later one in this order leaves its value in the RAM.
- R8: Let K be (enabled lanes) × (1+dual) × (1+wide). For a non-zero mask, `done_o` is high for one cycle, K+1 rising edges after the edge that accepted `start_i`. For an all-zero mask, `done_o` is high right after the accepting edge. `busy_o` is high from acceptance until `done_o` is raised.
- R9: Mode, mask, offsets and the bases of enabled lanes are sampled on the accepting edge. Later changes to these inputs do not affect the operation in flight.
- R10: `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| dual_i | input | 1 | 1: two offsets per lane; 0: one offset |
| write_i | input | 1 | 1: slots to RAM; 0: RAM to slots |
| wide_i | input | 1 | 1: 64-bit elements; 0: 32-bit elements |
| mask_i | input | LANES | Lane enable mask, bit i enables lane i |
| base_i | input | LANES*AW | Per-lane byte base address, lane i at bits i*AW upward |
| off0_i | input | AW | First immediate byte offset |
| off1_i | input | AW | Second immediate byte offset (dual mode) |
| wdata_i | input | 2*LANES*64 | Write slot vector, slot s at bits s*64 upward |
| slots_o | output | 2*LANES*64 | Slot file contents, slot s at bits s*64 upward |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A lane pointer or step counter in the wrong state shows up at `done_o` right away. The pulse lands on a different edge than the enabled-lane count predicts, and the latency is checked on every operation. A wrong address, slot index or word half on a read shows in `slots_o` as soon as `done_o` rises. A faulty write stays hidden until a later read op fetches the affected words, so the stimulus interleaves write and read operations over one shared 4 KiB image. The stimulus also changes every sampled input right after acceptance, so any path that reads a live input instead of a captured one corrupts the current result.

// File: rtl/lds_walk_pkg.sv
package lds_walk_pkg;
  localparam int WORD_W = 32;
  localparam int ELEM_W = 64;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_st_e;

  typedef struct packed {
    logic dual;
    logic write;
    logic wide;
  } op_cfg_t;
endpackage

// File: rtl/lds_lane_seq.sv
module lds_lane_seq import lds_walk_pkg::*; #(
  parameter int LANES = 64,
  localparam int LW = $clog2(LANES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [LANES-1:0] mask_i,
  input  op_cfg_t         cfg_i,
  output op_cfg_t         cfg_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            issue_o,
  output logic [LW-1:0]   lane_o,
  output logic            sel_o,
  output logic            half_o
);
  seq_st_e          st_q;
  logic [LANES-1:0] mask_q;
  op_cfg_t          cfg_q;
  logic [LW-1:0]    lane_q, first_lane, next_lane;
  logic [1:0]       step_q, step_max;
  logic             next_ok, step_last, done_q;

  // lowest enabled lane of the incoming mask
  always_comb begin
    first_lane = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (mask_i[i]) first_lane = LW'(i);
  end

  // lowest enabled lane above the current one
  always_comb begin
    next_lane = '0;
    next_ok   = 1'b0;
    for (int i = LANES - 1; i >= 0; i--)
      if (mask_q[i] && i > int'(lane_q)) begin
        next_lane = LW'(i);
        next_ok   = 1'b1;
      end
  end

  assign step_max  = (cfg_q.dual & cfg_q.wide) ? 2'd3 :
                     (cfg_q.dual | cfg_q.wide) ? 2'd1 : 2'd0;
  assign step_last = (step_q == step_max);
  assign half_o    = cfg_q.wide & step_q[0];
  assign sel_o     = cfg_q.dual & (cfg_q.wide ? step_q[1] : step_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      cfg_q  <= '0;
      lane_q <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mask_q <= mask_i;
          cfg_q  <= cfg_i;
          step_q <= '0;
          lane_q <= first_lane;
          if (|mask_i) st_q   <= ST_RUN;
          else         done_q <= 1'b1;
        end
        ST_RUN: begin
          if (step_last) begin
            step_q <= '0;
            if (next_ok) lane_q <= next_lane;
            else         st_q   <= ST_FIN;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
        ST_FIN: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_o   = cfg_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign issue_o = (st_q == ST_RUN);
  assign lane_o  = lane_q;

  p_issue_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> mask_q[lane_q]);

  p_lane_ascend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && $past(issue_o)) |-> (lane_q >= $past(lane_q)));

  p_step_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && $past(issue_o) && lane_q == $past(lane_q)) |->
      (step_q == $past(step_q) + 2'd1));
endmodule

// File: rtl/lds_addr_gen.sv
module lds_addr_gen #(
  parameter int LANES = 64,
  parameter int AW    = 12,
  localparam int LW = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [LANES*AW-1:0] base_i,
  input  logic [AW-1:0]     off0_i,
  input  logic [AW-1:0]     off1_i,
  input  logic [LW-1:0]     lane_i,
  input  logic              sel_i,
  input  logic              half_i,
  output logic [AW-1:0]     addr_o
);
  logic [AW-1:0] base_q [LANES];
  logic [AW-1:0] off0_q, off1_q;

  // bases of disabled lanes are never loaded
  for (genvar g = 0; g < LANES; g++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     base_q[g] <= '0;
      else if (capture_i && mask_i[g]) base_q[g] <= base_i[g*AW +: AW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off0_q <= '0;
      off1_q <= '0;
    end else if (capture_i) begin
      off0_q <= off0_i;
      off1_q <= off1_i;
    end
  end

  assign addr_o = base_q[lane_i] + (sel_i ? off1_q : off0_q)
                + (half_i ? AW'(4) : AW'(0));
endmodule

// File: rtl/lds_scratch_ram.sv
module lds_scratch_ram #(
  parameter int WORDS = 1024,
  parameter int WW    = 32,
  localparam int RW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [RW-1:0] addr_i,
  input  logic [WW-1:0] wdata_i,
  output logic [WW-1:0] rdata_o
);
  logic [WW-1:0] mem [WORDS];
  logic [WW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      else      rd_q        <= mem[addr_i];
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/lds_slot_file.sv
module lds_slot_file import lds_walk_pkg::*; #(
  parameter int NSLOT = 128,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic [SW-1:0]           idx_i,
  input  logic                    half_i,
  input  logic                    wide_i,
  input  logic [WORD_W-1:0]       ram_rdata_i,
  output logic [NSLOT*ELEM_W-1:0] slots_o
);
  logic [ELEM_W-1:0] slot_q [NSLOT];
  logic              pend_q, phalf_q, pwide_q;
  logic [SW-1:0]     pidx_q;

  // RAM data lands one cycle after the read is issued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      phalf_q <= 1'b0;
      pwide_q <= 1'b0;
      pidx_q  <= '0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else begin
      pend_q  <= rd_i;
      phalf_q <= half_i;
      pwide_q <= wide_i;
      pidx_q  <= idx_i;
      if (pend_q) begin
        if (!pwide_q)     slot_q[pidx_q]                  <= {{WORD_W{1'b0}}, ram_rdata_i};
        else if (phalf_q) slot_q[pidx_q][ELEM_W-1:WORD_W] <= ram_rdata_i;
        else              slot_q[pidx_q][WORD_W-1:0]      <= ram_rdata_i;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_out
    assign slots_o[g*ELEM_W +: ELEM_W] = slot_q[g];
  end
endmodule

// File: rtl/lds_lane_walker.sv
module lds_lane_walker import lds_walk_pkg::*; #(
  parameter int  LANES     = 64,
  parameter int  RAM_WORDS = 1024,
  localparam int AW        = $clog2(RAM_WORDS) + 2,
  localparam int NSLOT     = 2 * LANES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    dual_i,
  input  logic                    write_i,
  input  logic                    wide_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*AW-1:0]     base_i,
  input  logic [AW-1:0]           off0_i,
  input  logic [AW-1:0]           off1_i,
  input  logic [NSLOT*ELEM_W-1:0] wdata_i,
  output logic [NSLOT*ELEM_W-1:0] slots_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int LW = $clog2(LANES);
  localparam int SW = $clog2(NSLOT);
  localparam int RW = $clog2(RAM_WORDS);

  op_cfg_t           cfg_in, cfg;
  logic              accept, issue, sel, half;
  logic [LW-1:0]     lane;
  logic [SW-1:0]     slot_idx;
  logic [AW-1:0]     byte_addr;
  logic [ELEM_W-1:0] wchunk;
  logic [WORD_W-1:0] wword, rword;
  logic              ram_en, ram_we;

  assign cfg_in = '{dual: dual_i, write: write_i, wide: wide_i};
  assign accept = start_i & ~busy_o;

  lds_lane_seq #(.LANES(LANES)) u_seq (
    .clk_i, .rst_ni,
    .start_i (start_i),
    .mask_i  (mask_i),
    .cfg_i   (cfg_in),
    .cfg_o   (cfg),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .issue_o (issue),
    .lane_o  (lane),
    .sel_o   (sel),
    .half_o  (half)
  );

  lds_addr_gen #(.LANES(LANES), .AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .capture_i (accept),
    .mask_i    (mask_i),
    .base_i    (base_i),
    .off0_i    (off0_i),
    .off1_i    (off1_i),
    .lane_i    (lane),
    .sel_i     (sel),
    .half_i    (half),
    .addr_o    (byte_addr)
  );

  // dual mode interleaves two slots per lane
  assign slot_idx = cfg.dual ? {lane, sel} : SW'(lane);
  assign wchunk   = wdata_i[slot_idx*ELEM_W +: ELEM_W];
  assign wword    = half ? wchunk[ELEM_W-1:WORD_W] : wchunk[WORD_W-1:0];
  assign ram_en   = issue;
  assign ram_we   = issue & cfg.write;

  lds_scratch_ram #(.WORDS(RAM_WORDS), .WW(WORD_W)) u_ram (
    .clk_i,
    .en_i    (ram_en),
    .we_i    (ram_we),
    .addr_i  (byte_addr[AW-1:2]),
    .wdata_i (wword),
    .rdata_o (rword)
  );

  lds_slot_file #(.NSLOT(NSLOT)) u_slots (
    .clk_i, .rst_ni,
    .rd_i        (issue & ~cfg.write),
    .idx_i       (slot_idx),
    .half_i      (half),
    .wide_i      (cfg.wide),
    .ram_rdata_i (rword),
    .slots_o     (slots_o)
  );

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ram_en);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> !(done_o && busy_o));
endmodule

// File: tb/lds_lane_walker_test.sv
module lds_lane_walker_test;
  localparam int L     = 64;
  localparam int WORDS = 1024;
  localparam int AW    = 12;
  localparam int NS    = 2 * L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dual = 1'b0, write = 1'b0, wide = 1'b0;
  logic [L-1:0]    mask = '0;
  logic [L*AW-1:0] base = '0;
  logic [AW-1:0]   off0 = '0, off1 = '0;
  logic [NS*64-1:0] wdata = '0;
  logic [NS*64-1:0] slots;
  logic busy, done;

  int checks = 0, fails = 0;
  logic [31:0] shadow [WORDS];
  logic [63:0] exp_slot [NS];

  always #5ns clk = ~clk;

  lds_lane_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dual_i(dual),
    .write_i(write), .wide_i(wide), .mask_i(mask), .base_i(base),
    .off0_i(off0), .off1_i(off1), .wdata_i(wdata), .slots_o(slots),
    .busy_o(busy), .done_o(done)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(10ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got running exp finished");
    summary();
    $finish;
  end

  // reference model: walks lanes in order (R7) and returns expected latency (R8)
  function automatic int model(input bit d, w, wd, input logic [L-1:0] m,
                               input logic [L*AW-1:0] b, input logic [AW-1:0] o0, o1);
    int k = 0;
    for (int ln = 0; ln < L; ln++) begin
      if (!m[ln]) continue;   // R2
      for (int s = 0; s <= int'(d); s++) begin
        for (int h = 0; h <= int'(wd); h++) begin
          logic [AW-1:0] a;
          int sl;
          a  = b[ln*AW +: AW] + (s == 1 ? o1 : o0) + AW'(4 * h);
          sl = d ? 2 * ln + s : ln;
          k++;
          if (w) shadow[a[AW-1:2]] = wdata[sl*64 + 32*h +: 32];
          else if (wd) exp_slot[sl][32*h +: 32] = shadow[a[AW-1:2]];
          else exp_slot[sl] = {32'h0, shadow[a[AW-1:2]]};
        end
      end
    end
    return (m == '0) ? 1 : k + 2;
  endfunction

  task automatic run_op(input bit d, w, wd, input logic [L-1:0] m,
                        input logic [L*AW-1:0] b, input logic [AW-1:0] o0, o1,
                        input bit glitch, input string tag);
    int exp_lat, n, bad;
    exp_lat = model(d, w, wd, m, b, o0, o1);
    @(negedge clk);
    dual = d; write = w; wide = wd; mask = m; base = b; off0 = o0; off1 = o1;
    start = 1'b1;
    @(negedge clk);
    n = 1;
    start = glitch;  // R10: second start while busy
    // R9: disturb every sampled input after acceptance
    dual = ~d; write = ~w; wide = ~wd; mask = ~m; off0 = ~o0; off1 = o1 + 12'h40;
    for (int i = 0; i < L * AW / 32; i++) base[i*32 +: 32] = $urandom;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (n == 2) start = 1'b0;
    end
    start = 1'b0;
    checks++;
    if (n != exp_lat) begin
      fails++;
      $display("FAIL R8 %s: done latency got %0d exp %0d", tag, n, exp_lat);
    end
    checks++;
    bad = 0;
    for (int s = 0; s < NS; s++) begin
      if (slots[s*64 +: 64] !== exp_slot[s]) begin
        if (bad == 0)
          $display("FAIL %s: slot %0d got %h exp %h", tag, s, slots[s*64 +: 64], exp_slot[s]);
        bad++;
      end
    end
    if (bad != 0) fails++;
  endtask

  function automatic logic [L*AW-1:0] rand_bases();
    logic [L*AW-1:0] r;
    for (int i = 0; i < L; i++) r[i*AW +: AW] = AW'($urandom) & ~AW'(3);
    return r;
  endfunction

  task automatic rand_wdata();
    for (int i = 0; i < NS * 2; i++) wdata[i*32 +: 32] = $urandom;
  endtask

  initial begin
    logic [L*AW-1:0] b;
    logic [L-1:0] m;
    void'($urandom(32'h5eed_1d5));
    for (int s = 0; s < NS; s++) exp_slot[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++; if (busy !== 1'b0) begin fails++; $display("FAIL R1: busy got %b exp 0", busy); end
    checks++; if (done !== 1'b0) begin fails++; $display("FAIL R1: done got %b exp 0", done); end
    checks++; if (slots !== '0) begin fails++; $display("FAIL R1: slots got nonzero exp 0"); end

    // fill the whole RAM: dual wide writes, slots must stay zero (R5, R6)
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < L; i++) b[i*AW +: AW] = AW'(k * 1024 + i * 16);
      rand_wdata();
      run_op(1, 1, 1, '1, b, 12'd0, 12'd8, 0, "R5/R6 fill");
    end

    // directed corner cases
    for (int i = 0; i < L; i++) b[i*AW +: AW] = AW'(i * 4);
    run_op(0, 0, 0, '1, b, 12'd100, 12'd0, 0, "R3 single narrow read");
    run_op(0, 0, 0, '0, rand_bases(), 12'd0, 12'd0, 0, "R2 zero mask");
    run_op(1, 0, 1, 64'h8000_0000_0000_0000, rand_bases(), 12'd4, 12'd36, 0, "R4/R6 last lane dual wide");
    b = rand_bases(); b[5*AW +: AW] = 12'hFFC;
    run_op(0, 0, 1, 64'h20, b, 12'd8, 12'd0, 0, "R3 address wrap");
    rand_wdata();
    run_op(1, 1, 0, '1, rand_bases(), 12'd16, 12'd16, 0, "R7 same-word write order");
    run_op(1, 0, 0, '1, rand_bases(), 12'd0, 12'd16, 0, "R4 dual narrow read");
    run_op(1, 0, 1, 64'hF0F0_0000_1234_5678, rand_bases(), 12'd0, 12'd8, 1, "R10 start while busy");
    run_op(0, 0, 1, 64'h0000_FFFF_0000_0001, rand_bases(), 12'd20, 12'd0, 0, "R9 captured inputs");

    // constrained random mix
    for (int t = 0; t < 30; t++) begin
      bit d, w, wd;
      d = 1'($urandom); w = 1'($urandom); wd = 1'($urandom);
      case ($urandom % 4)
        0: m = {$urandom, $urandom};
        1: m = {$urandom, $urandom} & {$urandom, $urandom};
        2: m = '1;
        default: m = 64'h1 << ($urandom % 64);
      endcase
      if (w) rand_wdata();
      run_op(d, w, wd, m, rand_bases(), AW'($urandom) & ~AW'(3), AW'($urandom) & ~AW'(3),
             1'($urandom % 4 == 0), w ? "R5 random write" : (d ? "R4 random read" : "R3 random read"));
    end

    summary();
    $finish;
  end
endmodule